// File: doc/BRIEF.md
# Vectored Interrupt Controller with Acknowledge Decode

This block gathers sixteen interrupt sources into one active-low request line for a processor and answers the processor's interrupt-acknowledge cycle with a vector number. Sources 0 to 7 come from on-chip logic as one-clock event strobes. Sources 8 to 15 come from external pins. The pins are synchronised, and each pin has its own programmable active edge.

Software gates each source twice. The enable bit decides whether an event is latched at all. The mask bit decides whether a latched event may raise the request and take part in vector selection. The host also reads the synchronised pin levels directly, so it can poll the pins without taking interrupts.

The block recognises an acknowledge cycle from the processor's function-code, address and read/write lines. The next clock then brings data acknowledge low and drives a vector made of a programmable upper nibble and the index of the winning source. Source 15 has the highest priority. The winning pending bit is cleared once for each acknowledge cycle.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, irq_n and dtack_n are 1, vec_oe is 0, vec_data is 0, and every register (offsets 0 to 4) reads 0.
- R2: An internal strobe int_src[i] that is high at a clock edge while enable bit i is set sets pending bit i (register offset 0). The bit is readable after that edge.
- R3: Pin ext_pin[j] sets pending bit 8+j on its active edge. Config (offset 3) bit 8+j selects the edge: 1 is rising, 0 is falling. The bit appears on the third clock edge after the pin changes. The opposite edge sets nothing.
- R4: While enable bit k (offset 1) is 0, events on source k are ignored. A register write that clears enable bit k also clears pending bit k on the same edge.
- R5: A pending source whose mask bit (offset 2) is 0 stays pending. It does not pull irq_n low and is never chosen for the vector.
- R6: irq_n is 0 exactly when some bit is set in both pending and mask. It follows register changes one edge after the write or event.
- R7: A write to pending (offset 0) clears each bit written as 0 and keeps each bit written as 1. An event on the same edge as the write wins, and the bit stays set.
- R8: An acknowledge cycle is recognised only when bus_fc is 3'b111, bus_a (address bits 3..1) is 3'b110 and bus_rw is 0. Any other combination leaves dtack_n at 1.
- R9: One edge after the acknowledge cycle is recognised, dtack_n goes to 0 and vec_oe to 1. vec_data then carries {config bits 3:0, 4-bit index of the highest-numbered bit set in pending and mask}. These hold while the cycle lasts and drop one edge after it ends.
- R10: On the first edge of an acknowledge cycle, the pending bit of the selected source is cleared. A cycle held for several clocks clears only that one bit.
- R11: If no source is pending and unmasked when an acknowledge cycle starts, the vector is {config bits 3:0, 4'b0000} and no pending bit changes.
- R12: Offset 4 reads the synchronised pin levels in bits 7:0, with zeros above. A pin change shows on the second clock edge after it occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr |
| int_src | input | 8 | Internal event strobes, sources 0..7 |
| ext_pin | input | 8 | External interrupt pins, sources 8..15 |
| bus_fc | input | 3 | Processor function code |
| bus_a | input | 3 | Processor address bits 3..1 |
| bus_rw | input | 1 | Processor read/write, 1 is read |
| irq_n | output | 1 | Active-low interrupt request |
| dtack_n | output | 1 | Active-low data acknowledge |
| vec_data | output | 8 | Vector number |
| vec_oe | output | 1 | Vector drive enable |

## Verification
Register writes and internal strobes take effect on the edge that samples them, so the bench drives on the falling edge and checks at the next falling edge. Pin events take three edges and pin readback takes two. The bench checks one edge early to show that nothing arrives ahead of time. Acknowledge outputs are due one edge after the bus pattern is applied and fall one edge after it is removed. The bench reads the pending register while an acknowledge cycle is still held, which shows that only one bit was cleared.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    RA_PEND = 3'd0,
    RA_ENA  = 3'd1,
    RA_MASK = 3'd2,
    RA_CFG  = 3'd3,
    RA_PINS = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/vic_edge_sync.sv
module vic_edge_sync #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_i,
  input  logic [N-1:0] pol_i,
  output logic [N-1:0] level_o,
  output logic [N-1:0] edge_o
);
  for (genvar g = 0; g < N; g++) begin : g_pin
    logic s1_q, s2_q, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q   <= 1'b0;
        s2_q   <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        s1_q   <= pin_i[g];
        s2_q   <= s1_q;
        prev_q <= s2_q;
      end
    end

    assign level_o[g] = s2_q;
    assign edge_o[g]  = pol_i[g] ? (s2_q & ~prev_q) : (~s2_q & prev_q);
  end

  // R3: a detected edge lasts exactly one cycle
  a_r3_edge_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_o & $past(edge_o)) == '0);
endmodule

// File: rtl/vic_regs.sv
module vic_regs
  import vic_pkg::*;
#(
  parameter int N_SRC   = 16,
  parameter int N_EXT   = 8,
  parameter int BASE_W  = 4,
  parameter int POL_LSB = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [N_SRC-1:0]  wdata_i,
  input  logic [N_SRC-1:0]  pend_i,
  input  logic [N_EXT-1:0]  pins_i,
  output logic [N_SRC-1:0]  rdata_o,
  output logic [N_SRC-1:0]  ena_q_o,
  output logic [N_SRC-1:0]  ena_next_o,
  output logic [N_SRC-1:0]  mask_o,
  output logic [N_SRC-1:0]  pend_clr_o,
  output logic [BASE_W-1:0] base_o,
  output logic [N_EXT-1:0]  pol_o
);
  logic [N_SRC-1:0] ena_q, mask_q, cfg_q;
  logic             ena_we, mask_we, cfg_we, pend_we;

  always_comb begin
    ena_we  = 1'b0;
    mask_we = 1'b0;
    cfg_we  = 1'b0;
    pend_we = 1'b0;
    if (wr_i) begin
      case (addr_i)
        RA_PEND: pend_we = 1'b1;
        RA_ENA:  ena_we  = 1'b1;
        RA_MASK: mask_we = 1'b1;
        RA_CFG:  cfg_we  = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ena_q  <= '0;
      mask_q <= '0;
      cfg_q  <= '0;
    end else begin
      if (ena_we)  ena_q  <= wdata_i;
      if (mask_we) mask_q <= wdata_i;
      if (cfg_we)  cfg_q  <= wdata_i;
    end
  end

  assign ena_q_o    = ena_q;
  assign ena_next_o = ena_we ? wdata_i : ena_q;
  assign mask_o     = mask_q;
  assign pend_clr_o = pend_we ? ~wdata_i : '0;
  assign base_o     = cfg_q[BASE_W-1:0];
  assign pol_o      = cfg_q[POL_LSB +: N_EXT];

  always_comb begin
    case (addr_i)
      RA_PEND: rdata_o = pend_i;
      RA_ENA:  rdata_o = ena_q;
      RA_MASK: rdata_o = mask_q;
      RA_CFG:  rdata_o = cfg_q;
      RA_PINS: rdata_o = N_SRC'(pins_i);
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/vic_prio.sv
module vic_prio #(
  parameter int N     = 16,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     req_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign valid_o = |req_i;

  // R9: winner is set and nothing above it is set
  a_r9_prio_highest: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> ((req_i >> idx_o) == N'(1)));
endmodule

// File: rtl/vic_ack.sv
module vic_ack #(
  parameter int         VEC_W  = 8,
  parameter int         IDX_W  = 4,
  parameter logic [2:0] ACK_FC = 3'b111,
  parameter logic [2:0] ACK_A  = 3'b110,
  localparam int        BASE_W = VEC_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        fc_i,
  input  logic [2:0]        a_i,
  input  logic              rw_i,
  input  logic              valid_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [BASE_W-1:0] base_i,
  output logic              ack_go_o,
  output logic              dtack_n_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic              vec_oe_o
);
  logic             det, dtack_q;
  logic [VEC_W-1:0] vec_q, vec_d;

  assign det      = (fc_i == ACK_FC) && (a_i == ACK_A) && !rw_i;
  assign ack_go_o = det && !dtack_q;
  assign vec_d    = {base_i, valid_i ? idx_i : IDX_W'(0)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dtack_q <= 1'b0;
      vec_q   <= '0;
    end else begin
      dtack_q <= det;
      if (ack_go_o) vec_q <= vec_d;
    end
  end

  assign dtack_n_o = ~dtack_q;
  assign vec_o     = vec_q;
  assign vec_oe_o  = dtack_q;

  // R8: acknowledge only follows a decoded cycle on the previous edge
  a_r8_dtack_after_decode: assert property (@(posedge clk) disable iff (!rst_n)
    !dtack_n_o |-> $past((fc_i == ACK_FC) && (a_i == ACK_A) && !rw_i));
  // R9: vector is held for the length of the cycle
  a_r9_vec_held: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_oe_o && det) |=> $stable(vec_o));
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import vic_pkg::*;
#(
  parameter int N_INT = 8,
  parameter int N_EXT = 8,
  parameter int VEC_W = 8,
  localparam int N_SRC   = N_INT + N_EXT,
  localparam int IDX_W   = $clog2(N_SRC),
  localparam int BASE_W  = VEC_W - IDX_W,
  localparam int POL_LSB = N_INT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [N_SRC-1:0]  reg_wdata,
  output logic [N_SRC-1:0]  reg_rdata,
  input  logic [N_INT-1:0]  int_src,
  input  logic [N_EXT-1:0]  ext_pin,
  input  logic [2:0]        bus_fc,
  input  logic [2:0]        bus_a,
  input  logic              bus_rw,
  output logic              irq_n,
  output logic              dtack_n,
  output logic [VEC_W-1:0]  vec_data,
  output logic              vec_oe
);
  logic [N_SRC-1:0]  pend_q, pend_d, set_v, clr_v, ack_clr;
  logic [N_SRC-1:0]  ena_q, ena_next, mask_q, wr_clr, req;
  logic [N_EXT-1:0]  pin_lvl, pin_edge, pol;
  logic [BASE_W-1:0] base;
  logic              win_valid, ack_go;
  logic [IDX_W-1:0]  win_idx;

  vic_edge_sync #(.N(N_EXT)) u_edge (
    .clk(clk), .rst_n(rst_n), .pin_i(ext_pin), .pol_i(pol),
    .level_o(pin_lvl), .edge_o(pin_edge));

  vic_regs #(.N_SRC(N_SRC), .N_EXT(N_EXT), .BASE_W(BASE_W), .POL_LSB(POL_LSB)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_i(reg_wr), .addr_i(reg_addr), .wdata_i(reg_wdata),
    .pend_i(pend_q), .pins_i(pin_lvl), .rdata_o(reg_rdata), .ena_q_o(ena_q),
    .ena_next_o(ena_next), .mask_o(mask_q), .pend_clr_o(wr_clr), .base_o(base),
    .pol_o(pol));

  assign req = pend_q & mask_q;

  vic_prio #(.N(N_SRC), .IDX_W(IDX_W)) u_prio (
    .clk(clk), .rst_n(rst_n), .req_i(req), .valid_o(win_valid), .idx_o(win_idx));

  vic_ack #(.VEC_W(VEC_W), .IDX_W(IDX_W)) u_ack (
    .clk(clk), .rst_n(rst_n), .fc_i(bus_fc), .a_i(bus_a), .rw_i(bus_rw),
    .valid_i(win_valid), .idx_i(win_idx), .base_i(base), .ack_go_o(ack_go),
    .dtack_n_o(dtack_n), .vec_o(vec_data), .vec_oe_o(vec_oe));

  always_comb begin
    ack_clr = '0;
    if (ack_go && win_valid) ack_clr[win_idx] = 1'b1;
    set_v  = {pin_edge, int_src};
    clr_v  = wr_clr | ack_clr;
    pend_d = ((pend_q & ~clr_v) | set_v) & ena_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign irq_n = ~|req;

  // R4: nothing stays pending on a disabled source
  a_r4_pend_within_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q & ~ena_q) == '0);
  // R10: the acknowledged source is cleared unless re-raised on that edge
  a_r10_ack_clears_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_go && win_valid && !set_v[win_idx]) |=> !pend_q[$past(win_idx)]);
endmodule

// File: tb/irq_vector_ctrl_tb.sv
module irq_vector_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [7:0]  int_src = '0;
  logic [7:0]  ext_pin = '0;
  logic [2:0]  bus_fc = '0;
  logic [2:0]  bus_a = '0;
  logic        bus_rw = 1'b1;
  logic        irq_n, dtack_n, vec_oe;
  logic [7:0]  vec_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // {fc, a, rw, expect_ack}
  localparam logic [7:0] ACK_TBL [8] = '{
    {3'd7, 3'd6, 1'b0, 1'b1},
    {3'd7, 3'd6, 1'b1, 1'b0},
    {3'd6, 3'd6, 1'b0, 1'b0},
    {3'd7, 3'd7, 1'b0, 1'b0},
    {3'd7, 3'd2, 1'b0, 1'b0},
    {3'd3, 3'd6, 1'b0, 1'b0},
    {3'd7, 3'd6, 1'b0, 1'b1},
    {3'd5, 3'd6, 1'b0, 1'b0}
  };

  irq_vector_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .int_src(int_src),
    .ext_pin(ext_pin), .bus_fc(bus_fc), .bus_a(bus_a), .bus_rw(bus_rw),
    .irq_n(irq_n), .dtack_n(dtack_n), .vec_data(vec_data), .vec_oe(vec_oe));

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    step(1);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] a, input logic [15:0] exp);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic pulse(input logic [7:0] v);
    int_src = v;
    step(1);
    int_src = '0;
  endtask

  task automatic bus_ack(input logic [2:0] fc, input logic [2:0] a, input logic rw);
    bus_fc = fc; bus_a = a; bus_rw = rw;
  endtask

  task automatic bus_idle();
    bus_fc = '0; bus_a = '0; bus_rw = 1'b1;
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    chk("R1 irq_n", irq_n, 1);
    chk("R1 dtack_n", dtack_n, 1);
    chk("R1 vec_oe", vec_oe, 0);
    chk("R1 vec_data", vec_data, 0);
    for (int i = 0; i < 5; i++) rd_chk("R1 reg", 3'(i), 16'h0000);

    // R2 internal events
    wr(3'd1, 16'hFFFF);
    pulse(8'h05);
    rd_chk("R2 pend", 3'd0, 16'h0005);
    chk("R5 masked no irq", irq_n, 1);

    // R7 write-zero clear, event wins
    wr(3'd0, 16'hFFFE);
    rd_chk("R7 clear bit0", 3'd0, 16'h0004);
    reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 16'hFFFB; int_src = 8'h04;
    step(1);
    reg_wr = 1'b0; int_src = '0;
    rd_chk("R7 event wins", 3'd0, 16'h0004);

    // R4 enable gating
    wr(3'd1, 16'hFFFB);
    rd_chk("R4 disable clears", 3'd0, 16'h0000);
    pulse(8'h04);
    rd_chk("R4 event ignored", 3'd0, 16'h0000);
    wr(3'd1, 16'hFFFF);

    // R3 / R12 external pins: pin0 rising active, others falling
    wr(3'd3, 16'h0103);
    ext_pin = 8'h03;
    step(1);
    rd_chk("R12 pins early", 3'd4, 16'h0000);
    step(1);
    rd_chk("R12 pins", 3'd4, 16'h0003);
    rd_chk("R3 not yet", 3'd0, 16'h0000);
    step(1);
    rd_chk("R3 rising pin0", 3'd0, 16'h0100);
    ext_pin = 8'h01;
    step(3);
    rd_chk("R3 falling pin1", 3'd0, 16'h0300);
    ext_pin = 8'h00;
    step(3);
    rd_chk("R3 opposite edge ignored", 3'd0, 16'h0300);

    // R6 request follows pending and mask
    chk("R6 irq idle", irq_n, 1);
    wr(3'd2, 16'h0200);
    chk("R6 irq low", irq_n, 0);
    wr(3'd2, 16'h0000);
    chk("R6 irq high", irq_n, 1);
    wr(3'd2, 16'hFFFF);

    // R9 / R10 acknowledge, held two clocks
    bus_ack(3'd7, 3'd6, 1'b0);
    step(1);
    chk("R9 dtack", dtack_n, 0);
    chk("R9 vec_oe", vec_oe, 1);
    chk("R9 vector", vec_data, 8'h39);
    step(1);
    chk("R9 vector held", vec_data, 8'h39);
    rd_chk("R10 single clear", 3'd0, 16'h0100);
    bus_idle();
    step(1);
    chk("R9 dtack release", dtack_n, 1);
    chk("R9 vec_oe release", vec_oe, 0);
    bus_ack(3'd7, 3'd6, 1'b0);
    step(1);
    chk("R9 next vector", vec_data, 8'h38);
    bus_idle();
    step(1);
    rd_chk("R10 all cleared", 3'd0, 16'h0000);
    chk("R6 irq after ack", irq_n, 1);

    // R5 masked source not chosen; bit12 via falling pin4
    pulse(8'h08);
    ext_pin = 8'h10;
    step(3);
    ext_pin = 8'h00;
    step(3);
    rd_chk("R3 pin4 falling", 3'd0, 16'h1008);
    wr(3'd2, 16'h0008);
    chk("R5 irq", irq_n, 0);
    bus_ack(3'd7, 3'd6, 1'b0);
    step(1);
    chk("R5 vector skips masked", vec_data, 8'h33);
    bus_idle();
    step(1);
    rd_chk("R5 masked stays", 3'd0, 16'h1000);
    wr(3'd0, 16'h0000);
    wr(3'd2, 16'hFFFF);

    // R11 spurious acknowledge
    bus_ack(3'd7, 3'd6, 1'b0);
    step(1);
    chk("R11 dtack", dtack_n, 0);
    chk("R11 vector", vec_data, 8'h30);
    bus_idle();
    step(1);
    rd_chk("R11 pend", 3'd0, 16'h0000);

    // R8 decode table
    foreach (ACK_TBL[k]) begin
      pulse(8'h20);
      bus_ack(ACK_TBL[k][7:5], ACK_TBL[k][4:2], ACK_TBL[k][1]);
      step(1);
      chk("R8 decode", dtack_n, !ACK_TBL[k][0]);
      if (ACK_TBL[k][0]) chk("R8 vector", vec_data, 8'h35);
      bus_idle();
      step(1);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule